// File: doc/BRIEF.md
# Shift-and-Add Multiplier Datapath

This block holds the registers and arithmetic for an unsigned shift-and-add multiplier of parameter width N. An external sequencer drives it through four separate strobes: initialize, add, clear-carry and shift. It reads back two status bits: the low bit of the multiplier register, and a flag that is set when the step counter reaches zero. A multiplicand register, an accumulator, a multiplier/low-product register, a carry bit and a step down-counter make up its state.

Before a run, the operands are written through a simple load port while no strobe is active. A typical run works as follows. Initialize and clear-carry are pulsed together. Then, for each of the N multiplier bits, add is pulsed when the low status bit is 1, followed by a shift. The run ends after the shift during which the zero flag was already high. The 2N-bit product is then the accumulator placed above the low-product register.

Several strobes may be high in the same cycle. Their effects are then applied in the fixed order initialize, add, clear-carry, shift. Each one works on the result left by the ones before it.

Top module: `shmul_datapath`

## Requirements
- R1: After reset the accumulator, low-product register, multiplicand, carry and step counter are all zero, so `productOut` is 0, `qLsb` is 0 and `cntZero` is 1.
- R2: When `opLoad` is high and all four strobes are low, `mcandIn` is written to the multiplicand register and `mplierIn` to the low-product register, leaving the accumulator, carry and counter unchanged. When any strobe is high in that cycle, the operand write is ignored.
- R3: The initialize strobe clears the accumulator and loads the step counter with N-1.
- R4: The add strobe replaces the accumulator with the low N bits of accumulator plus multiplicand, and sets the carry to bit N of that sum.
- R5: The clear-carry strobe sets the carry to 0.
- R6: The shift strobe moves the (2N+1)-bit word carry|accumulator|low-product right by one place. The carry becomes 0, the old carry enters accumulator bit N-1, and accumulator bit 0 enters low-product bit N-1. The counter is decremented in the same cycle, and it wraps from 0 to all ones. The counter is max(1, ceil(log2 N)) bits wide.
- R7: Strobes active in one cycle apply in the order initialize, add, clear-carry, shift. With clear-carry and shift together, a 0 enters accumulator bit N-1. With add and shift together, the carry of the sum enters it. With initialize and shift together, the counter ends at N-2.
- R8: `cntZero` is 1 exactly when the counter holds 0. `qLsb` is bit 0 of the low-product register. `productOut` is the accumulator in bits 2N-1..N and the low-product register in bits N-1..0.
- R9: In a cycle with no strobe and no `opLoad`, no register changes.
- R10: Load, then initialize with clear-carry, then N steps are run. Each step is an add when `qLsb` is 1, followed by a shift alone. The run stops after the shift that was issued while `cntZero` was 1. At that point `productOut` equals the unsigned product of the two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opLoad | input | 1 | Operand write enable |
| mcandIn | input | N | Multiplicand value for the load port |
| mplierIn | input | N | Multiplier value for the load port |
| strbInit | input | 1 | Initialize strobe |
| strbAdd | input | 1 | Add strobe |
| strbClrC | input | 1 | Clear-carry strobe |
| strbShift | input | 1 | Shift-and-decrement strobe |
| productOut | output | 2N | Accumulator above low-product register |
| qLsb | output | 1 | Low bit of the low-product register |
| cntZero | output | 1 | Step counter equals zero |

## Verification
The bench tries each strobe alone on operands chosen to produce and not produce a carry, which shows whether the carry is kept and later shifted into the accumulator. Strobe pairs and the full set are driven in the same cycle with a carry pending; a wrong order of composition shows up as a 1 or 0 in the accumulator's top bit, or as a counter that is off by one. A long shift run from zero shows whether the counter wraps. Full multiplications with zero, all ones, a single set bit and mixed operands separate errors in the add, the carry and the step count, and a stream of random strobe mixes is compared cycle by cycle against a behavioural model.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
  typedef struct packed {
    logic init;
    logic add;
    logic clrC;
    logic shift;
  } mulStrobe_t;
endpackage

// File: rtl/shmul_strobe_ctrl.sv
module shmul_strobe_ctrl
  import shmul_pkg::*;
(
  input  logic       opLoad,
  input  logic       strbInit,
  input  logic       strbAdd,
  input  logic       strbClrC,
  input  logic       strbShift,
  output mulStrobe_t stb,
  output logic       loadEn
);
  always_comb begin
    stb.init  = strbInit;
    stb.add   = strbAdd;
    stb.clrC  = strbClrC;
    stb.shift = strbShift;
    // operand port only acts in a cycle free of microoperations
    loadEn = opLoad & ~(strbInit | strbAdd | strbClrC | strbShift);
  end
endmodule

// File: rtl/shmul_step_counter.sv
module shmul_step_counter
  import shmul_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  mulStrobe_t stb,
  output logic       cntZero
);
  localparam logic [CW-1:0] START = CW'(N - 1);

  logic [CW-1:0] cntR;
  logic [CW-1:0] cntNext;

  always_comb begin
    cntNext = cntR;
    if (stb.init)  cntNext = START;
    if (stb.shift) cntNext = cntNext - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntR <= '0;
    else       cntR <= cntNext;
  end

  assign cntZero = (cntR == '0);

  p_init_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.init && !stb.shift) |=> (cntR == START));

  p_dec_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.init) |=> (cntR == $past(cntR) - 1'b1));

  p_init_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.init && stb.shift) |=> (cntR == START - 1'b1));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.init && !stb.shift) |=> $stable(cntR));
endmodule

// File: rtl/shmul_arith.sv
module shmul_arith
  import shmul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulStrobe_t   stb,
  input  logic         loadEn,
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [N-1:0] accOut,
  output logic [N-1:0] lowOut
);
  logic [N-1:0] accR, lowR, bR;
  logic         carryR;
  logic [N-1:0] accW, lowW;
  logic         carryW;
  logic         anyStb;

  assign anyStb = stb.init | stb.add | stb.clrC | stb.shift;

  always_comb begin
    accW   = accR;
    lowW   = lowR;
    carryW = carryR;
    if (stb.init) accW = '0;
    if (stb.add)  {carryW, accW} = {1'b0, accW} + {1'b0, bR};
    if (stb.clrC) carryW = 1'b0;
    if (stb.shift) {carryW, accW, lowW} = {1'b0, carryW, accW, lowW[N-1:1]};
    if (loadEn)   lowW = mplier;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR   <= '0;
      lowR   <= '0;
      bR     <= '0;
      carryR <= 1'b0;
    end else begin
      accR   <= accW;
      lowR   <= lowW;
      carryR <= carryW;
      if (loadEn) bR <= mcand;
    end
  end

  assign accOut = accR;
  assign lowOut = lowR;

  p_opload_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (lowR == $past(mplier)) && (bR == $past(mcand)) && $stable(accR) && $stable(carryR));

  p_init_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.init && !stb.add && !stb.shift) |=> (accR == '0));

  p_add_sum_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.add && !stb.init && !stb.clrC && !stb.shift)
      |=> ({carryR, accR} == ({1'b0, $past(accR)} + {1'b0, $past(bR)})));

  p_clr_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrC |=> !carryR);

  p_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.init && !stb.add && !stb.clrC)
      |=> (lowR == {$past(accR[0]), $past(lowR[N-1:1])}) && (accR[N-1] == $past(carryR)) && !carryR);

  p_clr_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrC && stb.shift) |=> !accR[N-1]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStb && !loadEn) |=> $stable(accR) && $stable(lowR) && $stable(carryR) && $stable(bR));
endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath
  import shmul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opLoad,
  input  logic [N-1:0]   mcandIn,
  input  logic [N-1:0]   mplierIn,
  input  logic           strbInit,
  input  logic           strbAdd,
  input  logic           strbClrC,
  input  logic           strbShift,
  output logic [2*N-1:0] productOut,
  output logic           qLsb,
  output logic           cntZero
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;

  mulStrobe_t   stb;
  logic         loadEn;
  logic [N-1:0] accOut, lowOut;

  shmul_strobe_ctrl u_ctrl (
    .opLoad    (opLoad),
    .strbInit  (strbInit),
    .strbAdd   (strbAdd),
    .strbClrC  (strbClrC),
    .strbShift (strbShift),
    .stb       (stb),
    .loadEn    (loadEn)
  );

  shmul_arith #(.N(N)) u_arith (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .loadEn (loadEn),
    .mcand  (mcandIn),
    .mplier (mplierIn),
    .accOut (accOut),
    .lowOut (lowOut)
  );

  shmul_step_counter #(.N(N), .CW(CW)) u_count (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntZero (cntZero)
  );

  assign productOut = {accOut, lowOut};
  assign qLsb       = lowOut[0];

  p_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strbShift && !strbInit && !strbAdd && !strbClrC) |=> (qLsb == $past(productOut[1])));
endmodule

// File: tb/shmul_datapath_tb.sv
module shmul_datapath_tb;
  localparam int N  = 8;
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam longint unsigned MASK = (64'd1 << N) - 1;
  localparam longint unsigned PMOD = 64'd1 << CW;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           opLoad = 1'b0;
  logic [N-1:0]   mcandIn = '0, mplierIn = '0;
  logic           strbInit = 1'b0, strbAdd = 1'b0, strbClrC = 1'b0, strbShift = 1'b0;
  logic [2*N-1:0] productOut;
  logic           qLsb, cntZero;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  longint unsigned mA = 0, mQ = 0, mB = 0, mC = 0, mP = 0;

  always #4 clk = ~clk;

  shmul_datapath #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .opLoad(opLoad), .mcandIn(mcandIn), .mplierIn(mplierIn),
    .strbInit(strbInit), .strbAdd(strbAdd), .strbClrC(strbClrC), .strbShift(strbShift),
    .productOut(productOut), .qLsb(qLsb), .cntZero(cntZero)
  );

  task automatic check(input string tag, input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: integer arithmetic on the whole word
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA = 0; mQ = 0; mB = 0; mC = 0; mP = 0;
    end else begin
      longint unsigned a, q, c, p, s, w;
      a = mA; q = mQ; c = mC; p = mP;
      if (strbInit) begin a = 0; p = N - 1; end
      if (strbAdd) begin s = a + mB; a = s & MASK; c = s >> N; end
      if (strbClrC) c = 0;
      if (strbShift) begin
        w = (c << (2 * N)) + (a << N) + q;
        w = w >> 1;
        a = (w >> N) & MASK;
        q = w & MASK;
        c = 0;
        p = (p + PMOD - 1) % PMOD;
      end
      if (opLoad && !(strbInit || strbAdd || strbClrC || strbShift)) begin
        mB = mcandIn; q = mplierIn;
      end
      mA = a; mQ = q; mC = c; mP = p;
    end
  end

  always @(posedge clk) begin
    #2;
    check(curTag, "product", productOut, (mA << N) | mQ);
    check(curTag, "qLsb", qLsb, mQ & 1);
    check(curTag, "cntZero", cntZero, (mP == 0) ? 1 : 0);
  end

  task automatic drive(input bit ini, input bit ad, input bit cl, input bit sh,
                       input bit ld, input longint unsigned mc, input longint unsigned mp);
    @(negedge clk);
    strbInit = ini; strbAdd = ad; strbClrC = cl; strbShift = sh;
    opLoad = ld; mcandIn = N'(mc); mplierIn = N'(mp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic multiply(input longint unsigned a, input longint unsigned b);
    bit done;
    curTag = "R10";
    drive(0, 0, 0, 0, 1, a, b);
    drive(1, 0, 1, 0, 0, 0, 0);
    done = 0;
    while (!done) begin
      @(negedge clk);
      if (qLsb) begin
        strbInit = 0; strbAdd = 1; strbClrC = 0; strbShift = 0; opLoad = 0;
        @(negedge clk);
      end
      done = cntZero;
      strbInit = 0; strbAdd = 0; strbClrC = 0; strbShift = 1; opLoad = 0;
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #3;
    check("R10", "product of operands", productOut, a * b);
  endtask

  initial begin
    fork
      begin
        curTag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk); rstN = 1'b1;
        #1;
        check("R1", "product after reset", productOut, 0);
        check("R1", "zero flag after reset", cntZero, 1);
        check("R8", "qLsb after reset", qLsb, 0);
        idle(2);

        curTag = "R2";
        drive(0, 0, 0, 0, 1, 8'hC3, 8'h5A);
        drive(1, 0, 0, 0, 1, 8'h11, 8'h22);   // load ignored, init acts
        drive(0, 0, 0, 1, 1, 8'h33, 8'h44);   // load ignored, shift acts
        idle(1);
        @(posedge clk); #3;
        check("R2", "low half keeps earlier operand shifted once", productOut[N-1:0], 8'h2D);

        curTag = "R3";
        drive(1, 0, 0, 0, 0, 0, 0);
        curTag = "R4";
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);            // carry from C3+C3
        curTag = "R9";
        idle(3);
        curTag = "R6";
        drive(0, 0, 0, 1, 0, 0, 0);            // carry enters top of A
        idle(1);
        @(posedge clk); #3;
        check("R6", "carry shifted into accumulator msb", productOut[2*N-1], 1);

        curTag = "R5";
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        idle(1);

        curTag = "R7";
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);            // carry pending
        drive(0, 0, 1, 1, 0, 0, 0);            // 0 must enter msb
        idle(1);
        @(posedge clk); #3;
        check("R7", "clear with shift puts zero in msb", productOut[2*N-1], 0);
        drive(0, 1, 0, 1, 0, 0, 0);            // add fused with shift
        drive(1, 0, 0, 1, 0, 0, 0);            // counter to N-2
        drive(1, 1, 1, 1, 0, 0, 0);
        idle(1);

        curTag = "R6";
        drive(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < N + 4; i++) drive(0, 0, 0, 1, 0, 0, 0);   // passes zero and wraps
        idle(1);

        multiply(8'h26, 8'h35);
        multiply(8'hFF, 8'hFF);
        multiply(8'h00, 8'hA7);
        multiply(8'h80, 8'h01);
        multiply(8'h01, 8'h80);
        multiply(8'hAB, 8'hCD);

        curTag = "R7";
        for (int i = 0; i < 400; i++) begin
          int unsigned r;
          r = $urandom;
          drive(r[0], r[1], r[2], r[3], r[4], r[15:8], r[23:16]);
        end
        curTag = "R9";
        idle(4);
        multiply(8'h7F, 8'h81);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule